// File: doc/BRIEF.md
# Mixed-Width Byte FIFO Data Port

This block is a byte-granular circular buffer of 64 entries sitting behind one data register of a memory-mapped host interface. A processor reaches it with 8-bit, 16-bit or 32-bit accesses. A write stores 1, 2 or 4 bytes and a read removes 1, 2 or 4 bytes. In both directions the byte in the lowest lane of the bus comes first. The block keeps a read pointer and an occupancy count. When a read asks for more bytes than are stored, it returns zero and flags an underrun. When a write would exceed the capacity, the whole write is dropped and an overflow is flagged.

After every data access that succeeds, the block sends a one-cycle service request. The data-movement engine on the card side uses it to refill or drain the buffer. A narrow access to any other register offset is refused and flagged as a bad access. Full-width accesses to other offsets belong to neighbouring registers, so this block ignores them without a flag. The current fill level is always visible as a 7-bit count.

Top module: `byte_fifo_port`

## Requirements
- R1: While reset is asserted and on the cycle after its release, occupancy is 0, hostRdata is 0 and all four status pulses are low.
- R2: A 32-bit write (hostSize=2) to the data offset stores wdata[7:0] first, then [15:8], then [23:16], then [31:24], and raises occupancy by 4.
- R3: A 16-bit write (hostSize=1) stores wdata[7:0] then wdata[15:8] and raises occupancy by 2. An 8-bit write (hostSize=0) stores wdata[7:0] and raises occupancy by 1.
- R4: A read of 1, 2 or 4 bytes from the data offset returns the oldest byte in hostRdata[7:0] and the following bytes in ascending lanes. The unused upper lanes are zero, and occupancy drops by the byte count.
- R5: A read that asks for more bytes than occupancy holds returns hostRdata=0, leaves occupancy and stored data unchanged, and pulses underrun.
- R6: A write whose byte count would take occupancy above 64 stores nothing, leaves occupancy unchanged, and pulses overflow.
- R7: Positions wrap modulo 64, so byte order is preserved across the end of storage.
- R8: serviceReq pulses for one cycle after each data-offset access that moves bytes. It stays low after refused, dropped or foreign accesses. At most one of serviceReq, underrun, overflow and badAccess is high in any cycle.
- R9: An 8-bit or 16-bit access to any offset other than the data offset, or any access with hostSize=3, changes no state, returns hostRdata=0 on a read, and pulses badAccess.
- R10: A 32-bit access to another offset changes no state and raises no pulse, and a read of this kind returns hostRdata=0.
- R11: Occupancy never exceeds 64, and a write that lands exactly on 64 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Access request this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = illegal |
| hostAddr | input | 6 | Register offset |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data, loaded on each read access, held otherwise |
| occupancy | output | 7 | Stored byte count, 0 to 64 |
| serviceReq | output | 1 | One-cycle pulse after a successful data access |
| underrun | output | 1 | One-cycle pulse: read asked for too many bytes |
| overflow | output | 1 | One-cycle pulse: write dropped for lack of room |
| badAccess | output | 1 | One-cycle pulse: refused narrow or illegal access |

## Verification
All results, including read data, occupancy and the four pulses, appear in the cycle after the clock edge that captures the access. The access passes through exactly one register stage on its way to every output. The bench drives each access on a falling edge and removes it at the next falling edge. It then samples immediately, which is one rising edge after capture. A pulse that is still high at the following sample would therefore show up as a spurious flag on the next access.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  localparam int LANES = 4;
  localparam int BUS_W = LANES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic       loadRd;
    logic [2:0] nBytes;
  } fifoStrobe_t;
endpackage

// File: rtl/byte_fifo_ctrl.sv
module byte_fifo_ctrl
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DATA_OFFSET = 6'h2C,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [CNT_W-1:0]  count,
  output fifoStrobe_t       strobe,
  output logic              serviceReq,
  output logic              underrun,
  output logic              overflow,
  output logic              badAccess
);
  logic [2:0]     nBytes;
  logic           isData, legalSize, narrow, dataAcc, fits, enough;
  logic [CNT_W:0] afterPush;

  always_comb begin
    unique case (accSize_e'(hostSize))
      SZ_BYTE: nBytes = 3'd1;
      SZ_HALF: nBytes = 3'd2;
      SZ_WORD: nBytes = 3'd4;
      default: nBytes = 3'd0;
    endcase
  end

  assign isData    = (hostAddr == DATA_OFFSET);
  assign legalSize = (hostSize != SZ_BAD);
  assign narrow    = (hostSize != SZ_WORD);
  assign dataAcc   = hostValid && isData && legalSize;
  assign afterPush = {1'b0, count} + (CNT_W+1)'(nBytes);
  assign fits      = (afterPush <= (CNT_W+1)'(DEPTH));
  assign enough    = (count >= CNT_W'(nBytes));

  always_comb begin
    strobe.push   = dataAcc && hostWrite && fits;
    strobe.pop    = dataAcc && !hostWrite && enough;
    strobe.loadRd = hostValid && !hostWrite;
    strobe.nBytes = nBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serviceReq <= 1'b0;
      underrun   <= 1'b0;
      overflow   <= 1'b0;
      badAccess  <= 1'b0;
    end else begin
      serviceReq <= strobe.push || strobe.pop;
      underrun   <= dataAcc && !hostWrite && !enough;
      overflow   <= dataAcc && hostWrite && !fits;
      badAccess  <= hostValid && (!legalSize || (narrow && !isData));
    end
  end
endmodule

// File: rtl/byte_fifo_datapath.sv
module byte_fifo_datapath
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic [CNT_W-1:0] count
);
  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrBase;
  logic [PTR_W-1:0] wrIdx [LANES];
  logic [PTR_W-1:0] rdIdx [LANES];
  logic [BUS_W-1:0] popWord;

  assign wrBase = rdPtr + count[PTR_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign wrIdx[g] = wrBase + PTR_W'(g);
    assign rdIdx[g] = rdPtr + PTR_W'(g);
    assign popWord[g*8 +: 8] = (g < int'(strobe.nBytes)) ? store[rdIdx[g]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(strobe.nBytes)) store[wrIdx[i]] <= wdata[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      count <= '0;
      rdata <= '0;
    end else begin
      if (strobe.push) count <= count + CNT_W'(strobe.nBytes);
      if (strobe.pop) begin
        rdPtr <= rdPtr + PTR_W'(strobe.nBytes);
        count <= count - CNT_W'(strobe.nBytes);
      end
      if (strobe.loadRd) rdata <= strobe.pop ? popWord : '0;
    end
  end
endmodule

// File: rtl/byte_fifo_port.sv
module byte_fifo_port
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DATA_OFFSET = 6'h2C,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic [CNT_W-1:0]  occupancy,
  output logic              serviceReq,
  output logic              underrun,
  output logic              overflow,
  output logic              badAccess
);
  fifoStrobe_t strobe;

  byte_fifo_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_OFFSET(DATA_OFFSET)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostSize(hostSize), .hostAddr(hostAddr), .count(occupancy), .strobe(strobe),
    .serviceReq(serviceReq), .underrun(underrun), .overflow(overflow),
    .badAccess(badAccess)
  );

  byte_fifo_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(hostWdata),
    .rdata(hostRdata), .count(occupancy)
  );
endmodule

// File: rtl/byte_fifo_port_chk.sv
module byte_fifo_port_chk #(
  parameter int DEPTH = 64,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DATA_OFFSET = 6'h2C,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostValid,
  input logic              hostWrite,
  input logic [1:0]        hostSize,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [31:0]       hostRdata,
  input logic [CNT_W-1:0]  occupancy,
  input logic              serviceReq,
  input logic              underrun,
  input logic              overflow,
  input logic              badAccess
);
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({serviceReq, underrun, overflow, badAccess}));

  assert_underrun_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (occupancy == $past(occupancy)) && (hostRdata == 32'h0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> occupancy == $past(occupancy));

  assert_word_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostWrite && hostAddr == DATA_OFFSET && hostSize == 2'd2 &&
     occupancy <= CNT_W'(DEPTH - 4))
    |=> serviceReq && (occupancy == $past(occupancy) + CNT_W'(4)));

  assert_bad_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && (hostSize == 2'd3 || (hostSize != 2'd2 && hostAddr != DATA_OFFSET)))
    |=> badAccess && $stable(occupancy));

  assert_foreign_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && !hostWrite && hostAddr != DATA_OFFSET) |=> hostRdata == 32'h0);
endmodule

bind byte_fifo_port byte_fifo_port_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_OFFSET(DATA_OFFSET)
) u_chk (.*);

// File: tb/byte_fifo_port_tb.sv
module byte_fifo_port_tb;
  localparam logic [5:0] DOFS = 6'h2C;
  localparam logic [5:0] XOFS = 6'h10;
  localparam int NV = 13;
  // {write, size, addr, wdata, expRdata, checkRd, expCount, flags{svc,und,ovf,bad}}
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 2'd2, DOFS, 32'h44332211, 32'h0,        1'b0, 7'd4, 4'b1000}, // R2
    {1'b1, 2'd1, DOFS, 32'hAAAA6655, 32'h0,        1'b0, 7'd6, 4'b1000}, // R3
    {1'b1, 2'd0, DOFS, 32'hBBBBBB77, 32'h0,        1'b0, 7'd7, 4'b1000}, // R3
    {1'b0, 2'd2, DOFS, 32'h0,        32'h44332211, 1'b1, 7'd3, 4'b1000}, // R4
    {1'b0, 2'd1, DOFS, 32'h0,        32'h00006655, 1'b1, 7'd1, 4'b1000}, // R4
    {1'b0, 2'd1, DOFS, 32'h0,        32'h0,        1'b1, 7'd1, 4'b0100}, // R5
    {1'b0, 2'd0, DOFS, 32'h0,        32'h00000077, 1'b1, 7'd0, 4'b1000}, // R4
    {1'b0, 2'd0, DOFS, 32'h0,        32'h0,        1'b1, 7'd0, 4'b0100}, // R5
    {1'b1, 2'd0, XOFS, 32'h000000EE, 32'h0,        1'b0, 7'd0, 4'b0001}, // R9
    {1'b0, 2'd1, XOFS, 32'h0,        32'h0,        1'b1, 7'd0, 4'b0001}, // R9
    {1'b1, 2'd2, XOFS, 32'h12345678, 32'h0,        1'b0, 7'd0, 4'b0000}, // R10
    {1'b0, 2'd2, XOFS, 32'h0,        32'h0,        1'b1, 7'd0, 4'b0000}, // R10
    {1'b1, 2'd3, DOFS, 32'hCAFEF00D, 32'h0,        1'b0, 7'd0, 4'b0001}  // R9
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic hostValid = 1'b0, hostWrite = 1'b0;
  logic [1:0] hostSize = 2'd0;
  logic [5:0] hostAddr = 6'h0;
  logic [31:0] hostWdata = 32'h0, hostRdata;
  logic [6:0] occupancy;
  logic serviceReq, underrun, overflow, badAccess;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  byte_fifo_port u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FIFO port FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [5:0] ad, input logic [31:0] wd);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostSize = sz; hostAddr = ad; hostWdata = wd;
    @(negedge clk);
    hostValid = 1'b0;
  endtask

  function automatic logic [3:0] flagsNow();
    return {serviceReq, underrun, overflow, badAccess};
  endfunction

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 7 + 3);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(occupancy == 0 && hostRdata == 0 && flagsNow() == 0, "R1 in reset", {25'h0, occupancy}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(occupancy == 0 && flagsNow() == 0, "R1 after release", {28'h0, flagsNow()}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v][84], VEC[v][83:82], VEC[v][81:76], VEC[v][75:44]);
      check(occupancy == VEC[v][10:4], $sformatf("vec %0d count R2/R3/R4/R5", v), {25'h0, occupancy}, {25'h0, VEC[v][10:4]});
      check(flagsNow() == VEC[v][3:0], $sformatf("vec %0d flags R8/R9/R10", v), {28'h0, flagsNow()}, {28'h0, VEC[v][3:0]});
      if (VEC[v][11])
        check(hostRdata == VEC[v][43:12], $sformatf("vec %0d rdata R4/R5/R9/R10", v), hostRdata, VEC[v][43:12]);
    end

    // Read pointer now at 7: fill crosses the end of storage (R7).
    for (int w = 0; w < 15; w++)
      access(1'b1, 2'd2, DOFS, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
    access(1'b1, 2'd1, DOFS, {16'h0, pat(61), pat(60)});
    check(occupancy == 62, "R3 fill to 62", {25'h0, occupancy}, 32'd62);
    access(1'b1, 2'd2, DOFS, 32'hDEADBEEF);
    check(overflow && occupancy == 62, "R6 word overflow at 62", {25'h0, occupancy}, 32'd62);
    access(1'b1, 2'd1, DOFS, {16'h0, pat(63), pat(62)});
    check(occupancy == 64 && serviceReq, "R11 exact fill to 64", {25'h0, occupancy}, 32'd64);
    access(1'b1, 2'd0, DOFS, 32'h55);
    check(overflow && !serviceReq && occupancy == 64, "R6 byte overflow at 64", {25'h0, occupancy}, 32'd64);

    for (int w = 0; w < 16; w++) begin
      access(1'b0, 2'd2, DOFS, 32'h0);
      check(hostRdata == {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)},
            $sformatf("R7 wrap order word %0d", w), hostRdata,
            {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
    end
    check(occupancy == 0, "R4 drained", {25'h0, occupancy}, 32'h0);

    access(1'b1, 2'd2, DOFS, 32'h01020304);
    access(1'b0, 2'd2, DOFS, 32'h0);
    check(hostRdata == 32'h01020304, "R7 after wrap", hostRdata, 32'h01020304);

    access(1'b1, 2'd1, DOFS, 32'h0000BEEF);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(occupancy == 0 && hostRdata == 0 && flagsNow() == 0, "R1 mid-run reset", {25'h0, occupancy}, 32'h0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FIFO port FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule